// File: doc/BRIEF.md
# SPI Register Access Master

This block is an SPI master for peripherals that expose a register file behind a one-byte command. The host hands it one command: read or write, a 7-bit register address, a write byte and the index of the chip select to use. The block then runs a single two-byte full-duplex frame. The command byte carries a read flag in its top bit and the address below it. The second byte carries either the write data or zeros. For a read, the byte shifted in during the command byte is thrown away, and the byte shifted in during the second byte becomes the result.

The command side is a valid/ready channel. `cmd_ready` is high only while no frame is in progress. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. While `cmd_valid` is high the host keeps the command fields and the configuration inputs stable. A host that raises `cmd_valid` while the block is busy is simply not accepted until `cmd_ready` returns. The result has no back-pressure: `rsp_done` pulses for one cycle and `rsp_rdata` holds the last read byte until the next read completes.

Clock polarity, clock phase and the SCLK divider are plain configuration inputs. They are captured when a command is accepted, so all four SPI modes and any divider value can be chosen per transfer.

Top module: `spi_regio_master`

## Requirements
- R1: For a read, MOSI carries the 16 bits {1, addr[6:0], 8'h00}, most significant bit first.
- R2: For a write, MOSI carries the 16 bits {0, addr[6:0], wdata[7:0]}, most significant bit first.
- R3: After a read, `rsp_rdata` equals the 8 bits sampled from MISO during the second byte, first bit in the MSB position. Bits sampled during the first byte do not affect it, and a write leaves it unchanged.
- R4: Bit n of `spi_cs_n` is driven low only for n = `cmd_sel`. It goes low on the accepting edge and stays low until the frame ends. All other lines stay high. A `cmd_sel` of NUM_CS or more still runs the frame with every line high. Between frames all lines are high.
- R5: Between frames `spi_sclk` rests at `cfg_cpol`. A frame makes exactly 32 SCLK transitions and leaves SCLK back at the captured polarity.
- R6: With phase 0, MOSI holds its bit before the first edge, and both sides sample on leading edges (the edges that leave the idle level) and change on trailing edges. With phase 1, both sides change on leading edges and sample on trailing edges.
- R7: With H = `cfg_div`+1 clock cycles, the gap is H from select assertion to the first SCLK edge, between successive edges, and from the last edge to release. A frame spans 33*H cycles from acceptance to `rsp_done`.
- R8: `cmd_ready` is low for the whole frame. A `cmd_valid` raised during a frame starts no second frame.
- R9: `rsp_done` is a single-cycle pulse, seen in the cycle in which the select line is released.
- R10: During reset all select lines are high, `cmd_ready` is high, `rsp_done` is low and MOSI is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous-free synchronous reset |
| cfg_cpol | input | 1 | SCLK idle level |
| cfg_cpha | input | 1 | 0: sample on leading edge, 1: sample on trailing edge |
| cfg_div | input | DIV_W | Half SCLK period minus one, in clock cycles |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block idle, command can be taken |
| cmd_read | input | 1 | 1: register read, 0: register write |
| cmd_addr | input | 7 | Register address |
| cmd_wdata | input | 8 | Write data |
| cmd_sel | input | SEL_W | Chip-select index |
| rsp_done | output | 1 | One-cycle end-of-frame strobe |
| rsp_rdata | output | 8 | Last read result |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | NUM_CS | Active-low selects, one per peripheral |

## Verification
The bench builds the block with NUM_CS = 3 and DIV_W = 4. With three select lines, the 2-bit select index can take the value 3, which has no line, so the frame that drives no select at all is reachable. The narrow divider lets a single run cover the densest timing (H = 1 cycle), random small dividers and the top value 15 with short frames. A peripheral model in the bench follows the captured polarity and phase, so that all four modes are checked against both the MOSI pattern and the returned byte.

// File: rtl/spi_regio_pkg.sv
package spi_regio_pkg;

  localparam int ADDR_W  = 7;
  localparam int BYTE_W  = 8;
  localparam int FRAME_W = 2 * BYTE_W;
  localparam int EDGES   = 2 * FRAME_W;
  localparam int WIN_W   = $clog2(EDGES + 1);

  typedef enum logic [0:0] {
    ST_IDLE  = 1'b0,
    ST_FRAME = 1'b1
  } regio_state_t;

  // Command byte: read flag on top, address below; second byte zero on reads.
  function automatic logic [FRAME_W-1:0] build_frame(
    input logic              is_read,
    input logic [ADDR_W-1:0] addr,
    input logic [BYTE_W-1:0] wdata
  );
    logic [BYTE_W-1:0] second;
    second = is_read ? '0 : wdata;
    return {is_read, addr, second};
  endfunction

endpackage

// File: rtl/spi_regio_timer.sv
module spi_regio_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == div);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!run || tick) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R7: the half-period counter never runs past the divider value
  a_r7_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt <= div));

  // R7: with a divider above zero, ticks are never back to back
  a_r7_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (div != '0)) |=> !tick);

endmodule

// File: rtl/spi_regio_shift.sv
module spi_regio_shift
  import spi_regio_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               idle,
  input  logic               cpol_live,
  input  logic               load,
  input  logic [FRAME_W-1:0] frame_in,
  input  logic               cpha,
  input  logic               edge_en,
  input  logic [WIN_W-1:0]   edge_idx,
  input  logic               miso,
  output logic               sclk,
  output logic               mosi,
  output logic [BYTE_W-1:0]  rx_byte
);

  logic [FRAME_W-1:0] tx_q;
  logic               lead_edge;
  logic               sample_now;
  logic               launch_now;

  // Even edge numbers leave the idle level, odd ones return to it.
  assign lead_edge  = ~edge_idx[0];
  assign sample_now = lead_edge ^ cpha;
  // Phase 1 launches on leading edges; the very first bit is already out.
  assign launch_now = ~sample_now && (edge_idx != '0);

  assign mosi = idle ? 1'b0 : tx_q[FRAME_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk    <= 1'b0;
      tx_q    <= '0;
      rx_byte <= '0;
    end else if (load) begin
      tx_q    <= frame_in;
      rx_byte <= '0;
      sclk    <= cpol_live;
    end else if (idle) begin
      sclk <= cpol_live;
    end else if (edge_en) begin
      sclk <= ~sclk;
      if (sample_now) begin
        rx_byte <= {rx_byte[BYTE_W-2:0], miso};
      end
      if (launch_now) begin
        tx_q <= {tx_q[FRAME_W-2:0], 1'b0};
      end
    end
  end

  // R7: inside a frame SCLK moves only on a timer edge
  a_r7_sclk_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!idle) && !idle && !$stable(sclk)) |-> $past(edge_en));

  // R6: MOSI never changes on a sampling edge
  a_r6_mosi_steady_at_sample: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!idle) && $past(edge_en) && $past(sample_now)) |-> $stable(mosi));

endmodule

// File: rtl/spi_regio_master.sv
module spi_regio_master
  import spi_regio_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int DIV_W  = 8,
  localparam int SEL_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_read,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [BYTE_W-1:0] cmd_wdata,
  input  logic [SEL_W-1:0]  cmd_sel,
  output logic              rsp_done,
  output logic [BYTE_W-1:0] rsp_rdata,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic [NUM_CS-1:0] spi_cs_n
);

  regio_state_t       state;
  logic [WIN_W-1:0]   win;
  logic [DIV_W-1:0]   div_q;
  logic               cpol_q;
  logic               cpha_q;
  logic               rd_q;
  logic               tick;
  logic               accept;
  logic               last_win;
  logic               edge_en;
  logic               frame_end;
  logic [FRAME_W-1:0] frame_w;
  logic [BYTE_W-1:0]  rx_byte;

  assign cmd_ready = (state == ST_IDLE);
  assign accept    = cmd_valid && cmd_ready;
  assign last_win  = (win == WIN_W'(EDGES));
  assign edge_en   = tick && !last_win;
  assign frame_end = tick && last_win;
  assign frame_w   = build_frame(cmd_read, cmd_addr, cmd_wdata);

  spi_regio_timer #(.DIV_W(DIV_W)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (state == ST_FRAME),
    .div  (div_q),
    .tick (tick)
  );

  spi_regio_shift u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .idle     (state == ST_IDLE),
    .cpol_live(cfg_cpol),
    .load     (accept),
    .frame_in (frame_w),
    .cpha     (cpha_q),
    .edge_en  (edge_en),
    .edge_idx (win),
    .miso     (spi_miso),
    .sclk     (spi_sclk),
    .mosi     (spi_mosi),
    .rx_byte  (rx_byte)
  );

  // Window 0 is the lead-in, windows 1..32 follow the SCLK edges,
  // the tick closing window 32 releases the select.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      win       <= '0;
      div_q     <= '0;
      cpol_q    <= 1'b0;
      cpha_q    <= 1'b0;
      rd_q      <= 1'b0;
      rsp_done  <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            state  <= ST_FRAME;
            win    <= '0;
            div_q  <= cfg_div;
            cpol_q <= cfg_cpol;
            cpha_q <= cfg_cpha;
            rd_q   <= cmd_read;
          end
        end
        default: begin
          if (frame_end) begin
            state    <= ST_IDLE;
            rsp_done <= 1'b1;
            if (rd_q) begin
              rsp_rdata <= rx_byte;
            end
          end else if (tick) begin
            win <= win + 1'b1;
          end
        end
      endcase
    end
  end

  // One select flop per line; an index with no line leaves all high.
  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        spi_cs_n[g] <= 1'b1;
      end else if (accept) begin
        spi_cs_n[g] <= (cmd_sel != SEL_W'(g));
      end else if (frame_end) begin
        spi_cs_n[g] <= 1'b1;
      end
    end
  end

  // R4: at most one select line is low
  a_r4_cs_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~spi_cs_n));

  // R4: select lines hold still for the whole frame
  a_r4_cs_stable: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_FRAME) && $past(state == ST_FRAME)) |-> $stable(spi_cs_n));

  // R8: no command is taken while a select line is low
  a_r8_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_cs_n != '1) |-> !cmd_ready);

  // R9: the done strobe coincides with release and lasts one cycle
  a_r9_done_released: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> ((spi_cs_n == '1) && cmd_ready));

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  // R5: after 32 edges SCLK is back at the captured idle level
  a_r5_sclk_home: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> (spi_sclk == cpol_q));

endmodule

// File: tb/spi_regio_master_test.sv
module spi_regio_master_test;

  localparam int NUM_CS = 3;
  localparam int DIV_W  = 4;
  localparam int SEL_W  = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfg_cpol = 1'b0;
  logic              cfg_cpha = 1'b0;
  logic [DIV_W-1:0]  cfg_div = '0;
  logic              cmd_valid = 1'b0;
  logic              cmd_ready;
  logic              cmd_read = 1'b0;
  logic [6:0]        cmd_addr = '0;
  logic [7:0]        cmd_wdata = '0;
  logic [SEL_W-1:0]  cmd_sel = '0;
  logic              rsp_done;
  logic [7:0]        rsp_rdata;
  logic              spi_sclk;
  logic              spi_mosi;
  logic              spi_miso = 1'b0;
  logic [NUM_CS-1:0] spi_cs_n;

  spi_regio_master #(.NUM_CS(NUM_CS), .DIV_W(DIV_W)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
    .cfg_div(cfg_div), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_read(cmd_read), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .cmd_sel(cmd_sel), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .spi_cs_n(spi_cs_n)
  );

  always #10 clk = ~clk;  // 50 MHz

  int checks = 0;
  int fails  = 0;

  // Peripheral model and timing monitor state
  logic              cpol_b = 1'b0;
  logic              cpha_b = 1'b0;
  logic [15:0]       pat = '0;
  logic [NUM_CS-1:0] exp_cs = '1;
  int                hperiod = 1;
  logic [15:0]       cap = '0;
  logic              in_frame = 1'b0;
  logic              prev_ready = 1'b1;
  logic              prev_sclk = 1'b0;
  logic              is_lead;
  int cyc = 0, t0 = 0, last = 0, edges = 0, bad_int = 0, cs_bad = 0;
  int lead = 0, trail = 0, total = 0, frames = 0, p = 0;
  logic [7:0]        last_rd = '0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_mosi(input logic rd, input logic [6:0] a,
                                           input logic [7:0] d);
    if (rd) return {1'b1, a, 8'h00};
    return {1'b0, a, d};
  endfunction

  // Sample 5 ns after each rising edge, once the design has settled.
  always @(posedge clk) begin
    #5;
    cyc++;
    if (!rst_n) begin
      in_frame   = 1'b0;
      prev_ready = 1'b1;
      prev_sclk  = spi_sclk;
    end else begin
      if (prev_ready && !cmd_ready) begin
        in_frame = 1'b1;
        frames++;
        t0 = cyc; last = cyc; edges = 0; bad_int = 0; cap = '0; p = 15;
        cs_bad = (spi_cs_n != exp_cs) ? 1 : 0;
        spi_miso = cpha_b ? 1'b0 : pat[15];
      end else if (in_frame) begin
        if (!rsp_done && (spi_cs_n != exp_cs)) cs_bad++;
        if (spi_sclk != prev_sclk) begin
          if (edges == 0) lead = cyc - t0;
          else if (cyc - last != hperiod) bad_int++;
          last = cyc;
          edges++;
          is_lead = (spi_sclk != cpol_b);
          if (is_lead ^ cpha_b) begin
            cap = {cap[14:0], spi_mosi};
          end else if (!cpha_b) begin
            p--;
            if (p >= 0) spi_miso = pat[p];
          end else begin
            if (p >= 0) spi_miso = pat[p];
            p--;
          end
        end
        if (rsp_done) begin
          trail = cyc - last;
          total = cyc - t0;
          in_frame = 1'b0;
        end
      end
      prev_ready = cmd_ready;
      prev_sclk  = spi_sclk;
    end
  end

  task automatic xfer(input logic rd, input logic [6:0] a, input logic [7:0] d,
                      input logic [SEL_W-1:0] sel, input logic pol, input logic pha,
                      input logic [DIV_W-1:0] dv, input logic [7:0] dummy,
                      input logic [7:0] rbyte);
    int f0;
    @(negedge clk);
    cfg_cpol = pol; cfg_cpha = pha; cfg_div = dv;
    cpol_b = pol; cpha_b = pha; hperiod = int'(dv) + 1;
    pat = {dummy, rbyte};
    exp_cs = (int'(sel) < NUM_CS) ? ~(NUM_CS'(1) << sel) : '1;
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    f0 = frames;
    cmd_read = rd; cmd_addr = a; cmd_wdata = d; cmd_sel = sel; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(!cmd_ready, "R8 ready low in frame", cmd_ready, 0);
    // A competing command while busy must not start anything.
    cmd_read = ~rd; cmd_sel = sel + 1'b1; cmd_valid = 1'b1;
    @(negedge clk);
    chk(!cmd_ready, "R8 ready low with pending valid", cmd_ready, 0);
    cmd_valid = 1'b0;
    cmd_read = rd; cmd_sel = sel;
    while (!rsp_done) @(negedge clk);
    chk(frames == f0 + 1, "R8 one frame per command", frames - f0, 1);
    chk(cap == exp_mosi(rd, a, d), rd ? "R1 R6 read frame on MOSI" : "R2 R6 write frame on MOSI",
        cap, exp_mosi(rd, a, d));
    if (rd) last_rd = rbyte;
    chk(rsp_rdata == last_rd, "R3 R6 result byte", rsp_rdata, last_rd);
    chk(cs_bad == 0, "R4 select pattern in frame", cs_bad, 0);
    chk(spi_cs_n == '1, "R4 R9 released at done", spi_cs_n, 3'b111);
    chk(edges == 32, "R5 edge count", edges, 32);
    chk(spi_sclk == pol, "R5 SCLK idle level", spi_sclk, pol);
    chk(lead == hperiod && bad_int == 0 && trail == hperiod, "R7 lead/gap/trail",
        (lead << 16) | (bad_int << 8) | trail, (hperiod << 16) | hperiod);
    chk(total == 33 * hperiod, "R7 frame length", total, 33 * hperiod);
    @(negedge clk);
    chk(!rsp_done, "R9 done single cycle", rsp_done, 0);
    chk(rsp_rdata == last_rd, "R3 result held", rsp_rdata, last_rd);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got 0x0 expected 0x1");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'h5A17);
    cfg_cpol = 1'b1;
    repeat (3) @(negedge clk);
    chk(spi_cs_n == '1, "R10 selects high in reset", spi_cs_n, 3'b111);
    chk(cmd_ready, "R10 ready in reset", cmd_ready, 1);
    chk(!rsp_done, "R10 no done in reset", rsp_done, 0);
    chk(!spi_mosi, "R10 MOSI low in reset", spi_mosi, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(spi_sclk == 1'b1, "R5 SCLK follows polarity when idle", spi_sclk, 1);

    // Directed corners
    xfer(1'b1, 7'h7F, 8'hA5, 2'd0, 1'b0, 1'b0, 4'd0, 8'hFF, 8'h00);
    xfer(1'b0, 7'h00, 8'hFF, 2'd1, 1'b1, 1'b1, 4'd15, 8'h00, 8'hAA);
    xfer(1'b1, 7'h2A, 8'h00, 2'd3, 1'b0, 1'b1, 4'd2, 8'h5A, 8'hC3);
    xfer(1'b0, 7'h55, 8'h81, 2'd2, 1'b1, 1'b0, 4'd1, 8'h0F, 8'h3C);
    xfer(1'b1, 7'h01, 8'h00, 2'd2, 1'b1, 1'b0, 4'd0, 8'h00, 8'hFF);

    // Constrained random
    for (int i = 0; i < 40; i++) begin
      xfer(1'($urandom), 7'($urandom), 8'($urandom), 2'($urandom),
           1'($urandom), 1'($urandom), 4'($urandom % 4),
           8'($urandom), 8'($urandom));
    end

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule